// File: doc/BRIEF.md
# Inter-Core Mailbox Set/Clear Bank

This block keeps a bank of 32-bit mailboxes for signalling between processor cores. With the default parameters there are four cores and four mailboxes per core, so sixteen mailboxes in all. Mailbox `j` of core `c` has index `c*4 + j`. Software reaches each mailbox through two address aliases. In the set alias, a write ORs its data into the mailbox and a read returns zero. In the read/clear alias, a read returns the contents and a write clears every bit where the write data is one. The bank drives one pending flag per mailbox. The flag is high while that mailbox holds a nonzero value, and an interrupt router downstream uses it.

Access goes through a single 32-bit request port. The bank accepts a request in every cycle where `req_valid` is high. There is no back-pressure, so the port has no ready signal. A write takes effect at the clock edge that accepts it. Every accepted read gets a response one cycle later: `rsp_valid` pulses for one cycle with the data on `rsp_rdata`. The data is the value the mailbox held before that edge. Because there is only one port, a set and a clear can never reach the same mailbox in the same cycle.

Top module: `mbx_bank`

## Requirements
- R1: After reset all mailboxes are zero, `mbx_pending` is all zeros and `rsp_valid` is low.
- R2: A write to the set window (offsets 0x80 to 0xBF) ORs the write data into the selected mailbox.
- R3: A write to the read/clear window (offsets 0xC0 to 0xFF) clears each mailbox bit where the write data is one and leaves the other bits unchanged.
- R4: A read in the read/clear window returns the selected mailbox's contents as they were before the accepting edge.
- R5: A read in the set window returns zero.
- R6: In both windows the mailbox index is (offset minus window base) shifted right by 2, so the two low offset bits are ignored. Bit `k` of `mbx_pending` belongs to mailbox `k`, that is, core `k/4` and mailbox `k%4`.
- R7: Bit `k` of `mbx_pending` is high exactly when mailbox `k` is nonzero. It changes only in the cycle after an accepted write.
- R8: A read at an offset outside both windows returns zero. A write there changes no mailbox.
- R9: `rsp_valid` is high exactly one cycle after each accepted read and is low in every other cycle. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present; accepted in the same cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 12 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle pulse carrying read data |
| rsp_rdata | output | 32 | Read data, meaningful while `rsp_valid` is high |
| mbx_pending | output | 16 | Per-mailbox nonzero flags, bit k for mailbox k |

## Verification
The bench targets these corner cases:
- **Alias direction.** Reads from the set alias must give zero, and writes to the read/clear alias must clear bits rather than set them. A swapped decode would leak contents or OR bits in.
- **Window edges.** Offsets 0x7C, 0x100 and 0x200 lie just outside the windows. Unaligned offsets such as 0xC1 must map to the same mailbox as their aligned neighbour. A decoder with an off-by-one bound would hit a mailbox it should miss.
- **Partial clears and repeated sets.** A partial clear must leave the flag raised, and a second set must keep the earlier bits. A design that overwrites instead of merging would drop bits.
- **Read timing.** A read in the cycle right after a write must see the new value. A response pulse on writes, or one that lasts two cycles, is flagged at once.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_SET  = 2'd1,
    WIN_CLR  = 2'd2
  } win_e;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NUM_BOX  = 16,
  parameter int SET_BASE = 128,
  parameter int CLR_BASE = 192,
  localparam int IDX_W   = $clog2(NUM_BOX),
  localparam int SPAN    = NUM_BOX * 4
) (
  input  logic [ADDR_W-1:0] addr,
  output win_e              win,
  output logic [IDX_W-1:0]  idx
);
  logic [31:0] a;
  logic [31:0] off;

  always_comb begin
    a   = 32'(addr);
    win = WIN_NONE;
    off = '0;
    if (a >= 32'(SET_BASE) && a < 32'(SET_BASE + SPAN)) begin
      win = WIN_SET;
      off = a - 32'(SET_BASE);
    end else if (a >= 32'(CLR_BASE) && a < 32'(CLR_BASE + SPAN)) begin
      win = WIN_CLR;
      off = a - 32'(CLR_BASE);
    end
    idx = off[IDX_W+1:2];
  end
endmodule

// File: rtl/mbx_cell.sv
module mbx_cell #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q,
  output logic              pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (set_en) begin
      q <= q | wdata;
    end else if (clr_en) begin
      q <= q & ~wdata;
    end
  end

  assign pending = |q;
endmodule

// File: rtl/mbx_rdmux.sv
module mbx_rdmux #(
  parameter int NUM_BOX = 16,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_BOX)
) (
  input  logic [NUM_BOX-1:0][DATA_W-1:0] boxes,
  input  logic [IDX_W-1:0]               idx,
  input  logic                           sel_valid,
  output logic [DATA_W-1:0]              data
);
  always_comb begin
    data = '0;
    if (sel_valid) data = boxes[idx];
  end
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
  import mbx_pkg::*;
#(
  parameter int NUM_CORES    = 4,
  parameter int BOX_PER_CORE = 4,
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 12,
  parameter int SET_BASE     = 128,
  parameter int CLR_BASE     = 192,
  localparam int NUM_BOX     = NUM_CORES * BOX_PER_CORE,
  localparam int IDX_W       = $clog2(NUM_BOX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic [NUM_BOX-1:0] mbx_pending
);
  win_e                          win;
  logic [IDX_W-1:0]              idx;
  logic [NUM_BOX-1:0][DATA_W-1:0] boxes;
  logic                          wr_set, wr_clr, rd_acc, rd_clrwin;
  logic [DATA_W-1:0]             rd_data;

  mbx_decode #(
    .ADDR_W(ADDR_W), .NUM_BOX(NUM_BOX),
    .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
  ) u_dec (
    .addr(req_addr), .win(win), .idx(idx)
  );

  assign wr_set    = req_valid && req_write && (win == WIN_SET);
  assign wr_clr    = req_valid && req_write && (win == WIN_CLR);
  assign rd_acc    = req_valid && !req_write;
  assign rd_clrwin = rd_acc && (win == WIN_CLR);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    for (genvar j = 0; j < BOX_PER_CORE; j++) begin : g_box
      localparam int K = c * BOX_PER_CORE + j;
      logic hit;
      assign hit = (idx == IDX_W'(K));
      mbx_cell #(.DATA_W(DATA_W)) u_cell (
        .clk(clk), .rst_n(rst_n),
        .set_en(wr_set && hit), .clr_en(wr_clr && hit),
        .wdata(req_wdata), .q(boxes[K]), .pending(mbx_pending[K])
      );
    end
  end

  mbx_rdmux #(.NUM_BOX(NUM_BOX), .DATA_W(DATA_W)) u_rd (
    .boxes(boxes), .idx(idx), .sel_valid(rd_clrwin), .data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_acc;
      if (rd_acc) rsp_rdata <= rd_data;
    end
  end
endmodule

// File: rtl/mbx_bank_chk.sv
module mbx_bank_chk #(
  parameter int NUM_CORES    = 4,
  parameter int BOX_PER_CORE = 4,
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 12,
  parameter int SET_BASE     = 128,
  parameter int CLR_BASE     = 192,
  localparam int NUM_BOX     = NUM_CORES * BOX_PER_CORE,
  localparam int IDX_W       = $clog2(NUM_BOX),
  localparam int SPAN        = NUM_BOX * 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [DATA_W-1:0]  req_wdata,
  input logic               rsp_valid,
  input logic [DATA_W-1:0]  rsp_rdata,
  input logic [NUM_BOX-1:0] mbx_pending
);
  logic [31:0]      a;
  logic             in_set, in_clr, is_rd, is_wr;
  logic [IDX_W-1:0] sidx, cidx;
  logic             last_set_nz, last_clr_all;
  logic [IDX_W-1:0] last_set_idx, last_clr_idx;

  assign a      = 32'(req_addr);
  assign in_set = a >= 32'(SET_BASE) && a < 32'(SET_BASE + SPAN);
  assign in_clr = a >= 32'(CLR_BASE) && a < 32'(CLR_BASE + SPAN);
  assign sidx   = IDX_W'((a - 32'(SET_BASE)) >> 2);
  assign cidx   = IDX_W'((a - 32'(CLR_BASE)) >> 2);
  assign is_rd  = req_valid && !req_write;
  assign is_wr  = req_valid && req_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_set_nz  <= 1'b0;
      last_clr_all <= 1'b0;
      last_set_idx <= '0;
      last_clr_idx <= '0;
    end else begin
      last_set_nz  <= is_wr && in_set && (req_wdata != '0);
      last_clr_all <= is_wr && in_clr && (&req_wdata);
      last_set_idx <= sidx;
      last_clr_idx <= cidx;
    end
  end

  assert_rsp_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |=> rsp_valid);
  assert_no_rsp_otherwise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !is_rd |=> !rsp_valid);
  assert_set_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd && in_set |=> rsp_rdata == '0);
  assert_outside_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd && !in_set && !in_clr |=> rsp_rdata == '0);
  assert_outside_write_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr && !in_set && !in_clr |=> $stable(mbx_pending));
  assert_pending_only_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !is_wr |=> $stable(mbx_pending));
  assert_set_raises_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    last_set_nz |-> mbx_pending[last_set_idx]);
  assert_full_clear_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last_clr_all |-> !mbx_pending[last_clr_idx]);
endmodule

bind mbx_bank mbx_bank_chk #(
  .NUM_CORES(NUM_CORES), .BOX_PER_CORE(BOX_PER_CORE), .DATA_W(DATA_W),
  .ADDR_W(ADDR_W), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .mbx_pending(mbx_pending)
);

// File: tb/mbx_bank_tb.sv
module mbx_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [15:0] mbx_pending;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] model [16];

  always #2 clk = ~clk;

  mbx_bank u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .mbx_pending(mbx_pending)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // 0 = outside, 1 = set window, 2 = read/clear window
  function automatic int win_of(int addr, output int idx);
    idx = 0;
    if (addr >= 'h80 && addr < 'hC0) begin idx = (addr - 'h80) / 4; return 1; end
    if (addr >= 'hC0 && addr < 'h100) begin idx = (addr - 'hC0) / 4; return 2; end
    return 0;
  endfunction

  task automatic step(bit v, bit w, int addr, logic [31:0] d, string tag);
    int idx, win;
    bit exp_v;
    logic [31:0] exp_d;
    logic [15:0] exp_p;
    @(negedge clk);
    req_valid = v; req_write = w; req_addr = addr[11:0]; req_wdata = d;
    win   = win_of(addr, idx);
    exp_v = v && !w;
    exp_d = (exp_v && win == 2) ? model[idx] : 32'h0;
    @(posedge clk);
    if (v && w && win == 1) model[idx] = model[idx] | d;
    if (v && w && win == 2) model[idx] = model[idx] & ~d;
    #1;
    chk(rsp_valid === exp_v, {"R9 rsp_valid ", tag}, 32'(rsp_valid), 32'(exp_v));
    if (exp_v) chk(rsp_rdata === exp_d, {"rdata ", tag}, rsp_rdata, exp_d);
    for (int k = 0; k < 16; k++) exp_p[k] = (model[k] != 0);
    chk(mbx_pending === exp_p, {"R7 pending ", tag}, 32'(mbx_pending), 32'(exp_p));
  endtask

  initial begin
    for (int k = 0; k < 16; k++) model[k] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(mbx_pending === 16'h0, "R1 pending at reset", 32'(mbx_pending), 0);
    chk(rsp_valid === 1'b0, "R1 rsp_valid at reset", 32'(rsp_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 16; k++) step(1, 0, 'hC0 + 4*k, 0, "R1 reads zero");

    // R2 / R6: distinct pattern into every mailbox through the set window
    for (int k = 0; k < 16; k++) step(1, 1, 'h80 + 4*k, 32'h1 << k | 32'hA000_0000, "R2 set");
    step(1, 1, 'h94, 32'h0F00_0000, "R2 second set keeps bits");
    for (int k = 0; k < 16; k++) step(1, 0, 'hC0 + 4*k, 0, "R4 R6 read back");
    for (int k = 0; k < 16; k += 5) step(1, 0, 'h80 + 4*k, 0, "R5 set window read");
    step(1, 0, 'hC1, 0, "R6 unaligned read");
    step(1, 0, 'hFF, 0, "R6 top unaligned read");

    // R3: partial and full clears
    step(1, 1, 'hC4, 32'hA000_0000, "R3 partial clear");
    step(1, 0, 'hC4, 0, "R3 read after partial clear");
    step(1, 1, 'hC4, 32'hFFFF_FFFF, "R3 full clear");
    step(1, 0, 'hC4, 0, "R3 read after full clear");
    step(1, 1, 'hC8, 32'h0, "R3 clear with zero data");

    // R8: outside both windows
    step(1, 1, 'h7C, 32'hFFFF_FFFF, "R8 write below");
    step(1, 1, 'h100, 32'hFFFF_FFFF, "R8 write above");
    step(1, 1, 'h200, 32'hFFFF_FFFF, "R8 write far");
    step(1, 0, 'h7C, 0, "R8 read below");
    step(1, 0, 'h100, 0, "R8 read above");
    step(1, 0, 'h40, 0, "R8 read low");
    for (int k = 0; k < 16; k++) step(1, 0, 'hC0 + 4*k, 0, "R8 boxes intact");

    // R9: write-then-read and idle cycles
    step(1, 1, 'hBC, 32'h5, "R9 write no rsp");
    step(1, 0, 'hFC, 0, "R9 read sees prior write");
    step(0, 0, 'hFC, 0, "R9 idle");
    step(0, 1, 'hBC, 32'hFFFF, "R9 invalid write ignored");

    for (int n = 0; n < 400; n++) begin
      int sel, addr;
      sel = int'($urandom % 3);
      if (sel == 0) addr = 'h80 + int'($urandom % 64);
      else if (sel == 1) addr = 'hC0 + int'($urandom % 64);
      else addr = int'($urandom % 'h200);
      step($urandom % 4 != 0, $urandom % 2 == 1, addr,
           32'h1 << ($urandom % 32) | 32'h1 << ($urandom % 32), "R2 R3 mix");
    end
    for (int k = 0; k < 16; k++) step(1, 0, 'hC0 + 4*k, 0, "R4 final read");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule